// File: doc/BRIEF.md
# Multi-Queue Transmit Frame Scheduler

This block decides which transmit descriptor leaves next. It keeps up to sixteen circular descriptor rings. Each ring has a read pointer and a write pointer. Software moves a ring's write pointer forward as it posts descriptors. The scheduler moves the read pointer as descriptors are accepted downstream. Every ring is bound by configuration to one of eight DMA channels, and several rings may share a channel. Once per cycle the scheduler makes one grant:

- It picks the highest-numbered channel that has work and is ready.
- Among the rings feeding that channel, it rotates round-robin.
- It raises that channel's valid line, with the ring number and the descriptor index on shared buses.

Channels 0 to 3 carry background, best-effort, video and voice traffic, in rising priority. Channels 4 to 6 are spare. Channel 7 is the command channel and ranks above all others.

Each ring runs in one of two modes.

- **Windowed mode:** the read pointer steps on every accepted descriptor.
- **In-order mode:** an accepted descriptor holds the ring until a completion report arrives for it.
  - A positive report retires the descriptor.
  - A negative report sends the same descriptor again, until the number of failed attempts reaches `RETRY_LIMIT`. At that point the descriptor is dropped and the pointer moves on.

A ring bound to the command channel always runs in-order.

Configuration is written as a 20-bit status word per ring. A read port returns that word and both pointers of any selected ring.

Top module: `tx_frame_sched`

## Requirements
- R1: After reset every ring has both pointers at 0 and a status word of 0, and no channel valid is raised even with every channel ready.
- R2: The status word keeps the channel in bits 2:0, the active flag in bit 3, the windowed-mode select in bit 4 and the scheduling enable in bit 19. Every other bit reads back as 0.
- R3: A granted descriptor appears on the valid line of its ring's configured channel. `chQueue` carries the ring number and `chDesc` carries the ring's read pointer.
- R4: A ring is offered only when all of these hold: active flag 1, scheduling enable 1, read pointer different from write pointer, and no completion outstanding.
- R5: At most one valid is raised per cycle. Valid is raised only on a ready channel. The granted channel is the highest-numbered ready channel that has an eligible ring.
- R6: Rings sharing a channel are served round-robin. The search starts at the ring after the one last granted on that channel.
- R7: In windowed mode the read pointer advances by one on each grant and wraps from 255 to 0.
- R8: In in-order mode a grant blocks the ring until a completion report names it. A positive report advances the read pointer by one.
- R9: A negative report re-offers the same descriptor while the failure count stays below `RETRY_LIMIT` (default 3). The report that brings the count to the limit advances the read pointer instead.
- R10: A ring whose channel field is 7 (the command channel) is held in in-order mode. Its windowed-mode bit reads back as 0.
- R11: A completion report naming a ring with no outstanding descriptor changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write status word of `cfgQueue` |
| cfgQueue | input | 4 | Ring selected for the configuration write |
| cfgWord | input | 20 | Status word to write |
| ptrWe | input | 1 | Load write pointer of `ptrQueue` |
| ptrQueue | input | 4 | Ring selected for the pointer write |
| ptrValue | input | 8 | New write pointer |
| doneValid | input | 1 | Completion report present |
| doneQueue | input | 4 | Ring the report names |
| doneAck | input | 1 | 1 = acknowledged, 0 = attempt failed |
| chReady | input | 8 | Per-channel ready |
| chValid | output | 8 | Per-channel valid; at most one set |
| chQueue | output | 4 | Ring of the granted descriptor |
| chDesc | output | 8 | Index of the granted descriptor |
| statSel | input | 4 | Ring selected for readback |
| statWord | output | 20 | Status word of `statSel` |
| statRdPtr | output | 8 | Read pointer of `statSel` |
| statWrPtr | output | 8 | Write pointer of `statSel` |

## Verification
The assertions check the following on every cycle:
- Only one channel's valid is raised.
- A valid is never raised on a channel that is not ready.
- A grant always comes from an eligible, non-empty ring bound to the granted channel.
- A windowed grant moves the pointer by exactly one.
- An in-order grant leaves the ring blocked.
- No failure count reaches the retry limit.

The bench scenarios are needed for the ordering properties:
- which channel wins when several are ready;
- the rotation order among rings on one channel;
- re-offering of the same descriptor after failed attempts, and the drop at the limit;
- pointer wrap-around;
- read-back of the status-word field layout;
- stray completion reports having no effect.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int QIDX_W       = 4;
  localparam int CHAN_W       = 3;
  localparam int STAT_W       = 20;
  localparam int BIT_ACTIVE   = 3;
  localparam int BIT_WINDOW   = 4;
  localparam int BIT_SCHED_EN = 19;

  typedef struct packed {
    logic              grantValid;
    logic [QIDX_W-1:0] grantQueue;
    logic [CHAN_W-1:0] grantChan;
  } grant_strobe_t;
endpackage

// File: rtl/txs_queue_state.sv
module txs_queue_state
  import txs_pkg::*;
#(
  parameter int NUM_QUEUES  = 16,
  parameter int PTR_W       = 8,
  parameter int RETRY_LIMIT = 3,
  parameter int CMD_CHAN    = 7
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgWe,
  input  logic [QIDX_W-1:0]                    cfgQueue,
  input  logic [STAT_W-1:0]                    cfgWord,
  input  logic                                 ptrWe,
  input  logic [QIDX_W-1:0]                    ptrQueue,
  input  logic [PTR_W-1:0]                     ptrValue,
  input  logic                                 doneValid,
  input  logic [QIDX_W-1:0]                    doneQueue,
  input  logic                                 doneAck,
  input  grant_strobe_t                        strobe,
  input  logic [QIDX_W-1:0]                    statSel,
  output logic [STAT_W-1:0]                    statWord,
  output logic [PTR_W-1:0]                     statRdPtr,
  output logic [PTR_W-1:0]                     statWrPtr,
  output logic [NUM_QUEUES-1:0]                eligible,
  output logic [NUM_QUEUES-1:0][CHAN_W-1:0]    queueChan,
  output logic [NUM_QUEUES-1:0][PTR_W-1:0]     headDesc
);
  localparam int FAIL_W = 4;

  logic [NUM_QUEUES-1:0][PTR_W-1:0]  rdPtr, wrPtr;
  logic [NUM_QUEUES-1:0][CHAN_W-1:0] chan;
  logic [NUM_QUEUES-1:0][FAIL_W-1:0] failCnt;
  logic [NUM_QUEUES-1:0]             active, winMode, schedEn, waiting, finalTry;

  always_comb begin
    for (int q = 0; q < NUM_QUEUES; q++) begin
      finalTry[q] = (int'(failCnt[q]) + 1) >= RETRY_LIMIT;
      eligible[q] = active[q] && schedEn[q] && !waiting[q] && (rdPtr[q] != wrPtr[q]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      chan    <= '0;
      failCnt <= '0;
      active  <= '0;
      winMode <= '0;
      schedEn <= '0;
      waiting <= '0;
    end else begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        if (cfgWe && cfgQueue == QIDX_W'(q)) begin
          chan[q]    <= cfgWord[CHAN_W-1:0];
          active[q]  <= cfgWord[BIT_ACTIVE];
          schedEn[q] <= cfgWord[BIT_SCHED_EN];
          winMode[q] <= cfgWord[BIT_WINDOW] && (cfgWord[CHAN_W-1:0] != CHAN_W'(CMD_CHAN));
        end
        if (ptrWe && ptrQueue == QIDX_W'(q)) wrPtr[q] <= ptrValue;
        if (strobe.grantValid && strobe.grantQueue == QIDX_W'(q)) begin
          if (winMode[q]) rdPtr[q] <= rdPtr[q] + PTR_W'(1);
          else            waiting[q] <= 1'b1;
        end else if (doneValid && doneQueue == QIDX_W'(q) && waiting[q]) begin
          waiting[q] <= 1'b0;
          if (doneAck || finalTry[q]) begin
            rdPtr[q]   <= rdPtr[q] + PTR_W'(1);
            failCnt[q] <= '0;
          end else begin
            failCnt[q] <= failCnt[q] + FAIL_W'(1);
          end
        end
      end
    end
  end

  assign queueChan = chan;
  assign headDesc  = rdPtr;
  assign statRdPtr = rdPtr[statSel];
  assign statWrPtr = wrPtr[statSel];

  always_comb begin
    statWord                  = '0;
    statWord[CHAN_W-1:0]      = chan[statSel];
    statWord[BIT_ACTIVE]      = active[statSel];
    statWord[BIT_WINDOW]      = winMode[statSel];
    statWord[BIT_SCHED_EN]    = schedEn[statSel];
  end

  AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN) strobe.grantValid |-> (rdPtr[strobe.grantQueue] != wrPtr[strobe.grantQueue]) && !waiting[strobe.grantQueue]) else $error("grant from empty ring"); // R4
  AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (!rstN) strobe.grantValid && winMode[strobe.grantQueue] |=> rdPtr[$past(strobe.grantQueue)] == $past(rdPtr[strobe.grantQueue]) + PTR_W'(1)) else $error("window step"); // R7
  AST_INORDER_HOLD: assert property (@(posedge clk) disable iff (!rstN) strobe.grantValid && !winMode[strobe.grantQueue] |=> waiting[$past(strobe.grantQueue)]) else $error("in-order hold"); // R8

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_failChk
    AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (!rstN) int'(failCnt[g]) < RETRY_LIMIT) else $error("fail count"); // R9
  end
endmodule

// File: rtl/txs_arbiter.sv
module txs_arbiter
  import txs_pkg::*;
#(
  parameter int NUM_QUEUES   = 16,
  parameter int NUM_CHANNELS = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_QUEUES-1:0]             eligible,
  input  logic [NUM_QUEUES-1:0][CHAN_W-1:0] queueChan,
  input  logic [NUM_CHANNELS-1:0]           chReady,
  output grant_strobe_t                     strobe
);
  logic [NUM_CHANNELS-1:0][NUM_QUEUES-1:0] chReq;
  logic [NUM_CHANNELS-1:0][QIDX_W-1:0]     rrPtr;
  logic [CHAN_W-1:0]                       winChan;
  logic [QIDX_W-1:0]                       winQueue;
  logic                                    chanFound, queueFound;

  always_comb begin
    for (int c = 0; c < NUM_CHANNELS; c++)
      for (int q = 0; q < NUM_QUEUES; q++)
        chReq[c][q] = eligible[q] && (queueChan[q] == CHAN_W'(c));
  end

  // ascending scan: the last hit is the highest-ranked channel
  always_comb begin
    winChan   = '0;
    chanFound = 1'b0;
    for (int c = 0; c < NUM_CHANNELS; c++) begin
      if (chReady[c] && |chReq[c]) begin
        winChan   = CHAN_W'(c);
        chanFound = 1'b1;
      end
    end
  end

  always_comb begin
    winQueue   = '0;
    queueFound = 1'b0;
    for (int off = 1; off <= NUM_QUEUES; off++) begin
      if (!queueFound && chReq[winChan][(int'(rrPtr[winChan]) + off) % NUM_QUEUES]) begin
        winQueue   = QIDX_W'((int'(rrPtr[winChan]) + off) % NUM_QUEUES);
        queueFound = 1'b1;
      end
    end
  end

  assign strobe.grantValid = chanFound && queueFound;
  assign strobe.grantQueue = winQueue;
  assign strobe.grantChan  = winChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rrPtr <= '0;
    else if (strobe.grantValid) rrPtr[strobe.grantChan] <= strobe.grantQueue;
  end

  AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rstN) strobe.grantValid |-> chReady[strobe.grantChan] && eligible[strobe.grantQueue] && (queueChan[strobe.grantQueue] == strobe.grantChan)) else $error("illegal grant"); // R3
endmodule

// File: rtl/tx_frame_sched.sv
module tx_frame_sched
  import txs_pkg::*;
#(
  parameter int NUM_QUEUES   = 16,
  parameter int NUM_CHANNELS = 8,
  parameter int PTR_W        = 8,
  parameter int RETRY_LIMIT  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [QIDX_W-1:0]       cfgQueue,
  input  logic [STAT_W-1:0]       cfgWord,
  input  logic                    ptrWe,
  input  logic [QIDX_W-1:0]       ptrQueue,
  input  logic [PTR_W-1:0]        ptrValue,
  input  logic                    doneValid,
  input  logic [QIDX_W-1:0]       doneQueue,
  input  logic                    doneAck,
  input  logic [NUM_CHANNELS-1:0] chReady,
  output logic [NUM_CHANNELS-1:0] chValid,
  output logic [QIDX_W-1:0]       chQueue,
  output logic [PTR_W-1:0]        chDesc,
  input  logic [QIDX_W-1:0]       statSel,
  output logic [STAT_W-1:0]       statWord,
  output logic [PTR_W-1:0]        statRdPtr,
  output logic [PTR_W-1:0]        statWrPtr
);
  localparam int CMD_CHAN = NUM_CHANNELS - 1;

  grant_strobe_t                     strobe;
  logic [NUM_QUEUES-1:0]             eligible;
  logic [NUM_QUEUES-1:0][CHAN_W-1:0] queueChan;
  logic [NUM_QUEUES-1:0][PTR_W-1:0]  headDesc;

  txs_queue_state #(
    .NUM_QUEUES(NUM_QUEUES), .PTR_W(PTR_W), .RETRY_LIMIT(RETRY_LIMIT), .CMD_CHAN(CMD_CHAN)
  ) i_state (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgQueue(cfgQueue), .cfgWord(cfgWord),
    .ptrWe(ptrWe), .ptrQueue(ptrQueue), .ptrValue(ptrValue),
    .doneValid(doneValid), .doneQueue(doneQueue), .doneAck(doneAck),
    .strobe(strobe), .statSel(statSel),
    .statWord(statWord), .statRdPtr(statRdPtr), .statWrPtr(statWrPtr),
    .eligible(eligible), .queueChan(queueChan), .headDesc(headDesc)
  );

  txs_arbiter #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_CHANNELS(NUM_CHANNELS)
  ) i_arb (
    .clk(clk), .rstN(rstN), .eligible(eligible), .queueChan(queueChan),
    .chReady(chReady), .strobe(strobe)
  );

  always_comb begin
    chValid = '0;
    if (strobe.grantValid) chValid[strobe.grantChan] = 1'b1;
  end

  assign chQueue = strobe.grantQueue;
  assign chDesc  = headDesc[strobe.grantQueue];

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(chValid)) else $error("multiple valids"); // R5
  AST_VALID_READY: assert property (@(posedge clk) disable iff (!rstN) (chValid & ~chReady) == '0) else $error("valid on unready channel"); // R5
endmodule

// File: tb/test_tx_frame_sched.sv
module test_tx_frame_sched;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe, ptrWe, doneValid, doneAck;
  logic [3:0]  cfgQueue, ptrQueue, doneQueue, statSel, chQueue;
  logic [19:0] cfgWord, statWord;
  logic [7:0]  ptrValue, chReady, chValid, chDesc, statRdPtr, statWrPtr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tx_frame_sched i_tx_frame_sched (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgQueue(cfgQueue), .cfgWord(cfgWord),
    .ptrWe(ptrWe), .ptrQueue(ptrQueue), .ptrValue(ptrValue),
    .doneValid(doneValid), .doneQueue(doneQueue), .doneAck(doneAck),
    .chReady(chReady), .chValid(chValid), .chQueue(chQueue), .chDesc(chDesc),
    .statSel(statSel), .statWord(statWord), .statRdPtr(statRdPtr), .statWrPtr(statWrPtr)
  );

  // {ring[23:20], channel[19:16], expected valid[15:8], expected descriptor[7:0]}
  localparam logic [23:0] VEC [6] = '{24'h000100, 24'h530800, 24'h910200,
                                      24'hF20400, 24'h364000, 24'h910201};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] q, input logic [19:0] w);
    @(negedge clk); cfgWe = 1'b1; cfgQueue = q; cfgWord = w;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic ptrWrite(input logic [3:0] q, input logic [7:0] v);
    @(negedge clk); ptrWe = 1'b1; ptrQueue = q; ptrValue = v;
    @(negedge clk); ptrWe = 1'b0;
  endtask

  task automatic doneSend(input logic [3:0] q, input logic ack);
    @(negedge clk); doneValid = 1'b1; doneQueue = q; doneAck = ack;
    @(negedge clk); doneValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 0; ptrWe = 0; doneValid = 0; doneAck = 0;
    cfgQueue = 0; ptrQueue = 0; doneQueue = 0; statSel = 0;
    cfgWord = 0; ptrValue = 0; chReady = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    check(chValid == 8'h00, "R1 no valid in reset", chValid, 0);
    check(statWord == 0 && statRdPtr == 0 && statWrPtr == 0, "R1 reset state", statWord, 0);
    @(negedge clk); rstN = 1'b1; chReady = 8'h00;

    // R2 and R10: field layout and command-channel mode lock
    cfgWrite(4'd2, 20'hFFFFF);
    cfgWrite(4'd4, 20'hFFFFD);
    statSel = 4'd2; #1;
    check(statWord == 20'h8000F, "R10 command ring forced in-order", statWord, 20'h8000F);
    statSel = 4'd4; #1;
    check(statWord == 20'h8001D, "R2 status layout", statWord, 20'h8001D);
    cfgWrite(4'd2, 20'h0);
    cfgWrite(4'd4, 20'h0);

    // R3 / R7: table walk, windowed rings on several channels
    for (int i = 0; i < 6; i++) begin
      automatic logic [3:0] vq  = VEC[i][23:20];
      automatic logic [3:0] vch = VEC[i][19:16];
      automatic logic [7:0] vv  = VEC[i][15:8];
      automatic logic [7:0] vd  = VEC[i][7:0];
      chReady = 8'h00;
      cfgWrite(vq, 20'h80018 | {17'b0, vch[2:0]});
      ptrWrite(vq, vd + 8'd1);
      chReady = 8'hFF; #1;
      check(chValid == vv, "R3 channel routing", chValid, vv);
      check(chQueue == vq, "R3 ring index", chQueue, vq);
      check(chDesc == vd, "R3 descriptor index", chDesc, vd);
      @(negedge clk); chReady = 8'h00; statSel = vq; #1;
      check(statRdPtr == vd + 8'd1, "R7 windowed step", statRdPtr, vd + 8'd1);
    end

    // R4: eligibility gates
    cfgWrite(4'd6, 20'h00019);
    ptrWrite(4'd6, 8'd1);
    chReady = 8'hFF; #1;
    check(chValid == 8'h00, "R4 enable clear", chValid, 0);
    @(negedge clk); chReady = 8'h00;
    cfgWrite(4'd6, 20'h80011);
    chReady = 8'hFF; #1;
    check(chValid == 8'h00, "R4 inactive", chValid, 0);
    @(negedge clk); chReady = 8'h00;
    cfgWrite(4'd6, 20'h80019);
    chReady = 8'hFF; #1;
    check(chValid == 8'h02 && chQueue == 4'd6, "R4 eligible", {chValid, 4'h0, chQueue}, 32'h0206);
    @(negedge clk); chReady = 8'h00;

    // R5: channel priority
    cfgWrite(4'd7, 20'h80018);
    cfgWrite(4'd8, 20'h8001B);
    cfgWrite(4'd10, 20'h8000F);
    ptrWrite(4'd7, 8'd1);
    ptrWrite(4'd8, 8'd1);
    ptrWrite(4'd10, 8'd1);
    chReady = 8'b0000_1001; #1;
    check(chValid == 8'h08 && chQueue == 4'd8, "R5 highest ready wins", {chValid, 4'h0, chQueue}, 32'h0808);
    @(negedge clk); chReady = 8'h01; #1;
    check(chValid == 8'h01 && chQueue == 4'd7, "R5 unready channel skipped", {chValid, 4'h0, chQueue}, 32'h0107);
    @(negedge clk); chReady = 8'hFF; #1;
    check(chValid == 8'h80 && chQueue == 4'd10, "R5 command channel first", {chValid, 4'h0, chQueue}, 32'h800A);
    @(negedge clk); chReady = 8'h00;
    doneSend(4'd10, 1'b1);
    statSel = 4'd10; #1;
    check(statRdPtr == 8'd1, "R8 command ack advances", statRdPtr, 1);

    // R6: round-robin on channel 2
    cfgWrite(4'd11, 20'h8001A);
    cfgWrite(4'd12, 20'h8001A);
    cfgWrite(4'd13, 20'h8001A);
    ptrWrite(4'd11, 8'd2);
    ptrWrite(4'd12, 8'd2);
    ptrWrite(4'd13, 8'd2);
    chReady = 8'hFF;
    for (int k = 0; k < 6; k++) begin
      #1;
      check(chValid == 8'h04 && chQueue == 4'(11 + k % 3), "R6 rotation order", chQueue, 11 + k % 3);
      check(chDesc == 8'(k / 3), "R6 descriptor", chDesc, k / 3);
      @(negedge clk);
    end
    chReady = 8'h00;

    // R7: wrap from 255 to 0
    cfgWrite(4'd14, 20'h80019);
    ptrWrite(4'd14, 8'hFF);
    chReady = 8'hFF;
    repeat (260) @(negedge clk);
    chReady = 8'h00; statSel = 4'd14; #1;
    check(statRdPtr == 8'hFF, "R7 ring drained to 255", statRdPtr, 8'hFF);
    ptrWrite(4'd14, 8'h00);
    chReady = 8'hFF; #1;
    check(chValid == 8'h02 && chDesc == 8'hFF, "R7 last slot offered", chDesc, 8'hFF);
    @(negedge clk); chReady = 8'h00; #1;
    check(statRdPtr == 8'h00, "R7 wrap to 0", statRdPtr, 0);

    // R8 / R9: in-order ring with failures
    cfgWrite(4'd1, 20'h80008);
    ptrWrite(4'd1, 8'd1);
    chReady = 8'hFF; #1;
    check(chValid == 8'h01 && chQueue == 4'd1 && chDesc == 8'd0, "R8 first offer", chDesc, 0);
    @(negedge clk); #1;
    check(chValid == 8'h00, "R8 blocked while outstanding", chValid, 0);
    for (int a = 0; a < 3; a++) begin
      doneSend(4'd1, 1'b0);
      #1;
      if (a < 2) begin
        check(chValid == 8'h01 && chQueue == 4'd1 && chDesc == 8'd0, "R9 same descriptor again", chDesc, 0);
      end else begin
        statSel = 4'd1; #1;
        check(chValid == 8'h00 && statRdPtr == 8'd1, "R9 dropped at limit", statRdPtr, 1);
      end
    end
    ptrWrite(4'd1, 8'd2);
    #1;
    check(chValid == 8'h01 && chDesc == 8'd1, "R8 next descriptor offered", chDesc, 1);
    doneSend(4'd1, 1'b1);
    statSel = 4'd1; #1;
    check(statRdPtr == 8'd2 && chValid == 8'h00, "R8 ack advances", statRdPtr, 2);

    // R11: stray completion reports
    doneSend(4'd1, 1'b1);
    doneSend(4'd5, 1'b0);
    statSel = 4'd1; #1;
    check(statRdPtr == 8'd2, "R11 stray report on idle in-order ring", statRdPtr, 2);
    statSel = 4'd5; #1;
    check(statRdPtr == 8'd1, "R11 stray report on windowed ring", statRdPtr, 1);
    check(chValid == 8'h00, "R11 nothing offered", chValid, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule